// File: doc/BRIEF.md
# Vector Saturating Right-Shift-and-Narrow Unit

This unit takes a 128-bit source vector made of wide elements. It shifts every element right by an immediate amount, with optional rounding, and reduces each result to half its width. The half-width values are packed into a 128-bit result vector. Narrow elements can be 8, 16 or 32 bits wide, so the source elements are 16, 32 or 64 bits wide. Each narrowed value is handled in one of three ways: clamped to a signed range, clamped to an unsigned range, or truncated to its low bits.

The packed results go into the lower 64 bits of the result, with the upper 64 bits cleared. In the upper-half form they go into the upper 64 bits, and the lower 64 bits are copied from a second operand that holds the previous destination value. A scalar mode produces only element 0. A request is accepted on every cycle in which it is valid. Its result is registered and appears one cycle later, together with a flag that is set when any lane that contributes to the result was clamped.

Top module: `shrn_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the unit clears rsp_valid, rsp_data and rsp_sat to zero.
- R2: req_ready is always high. A request with req_valid high at a clock edge gives rsp_valid high after that edge, and rsp_data and rsp_sat hold the result of that request. After an edge with no request, rsp_valid is low and rsp_data and rsp_sat keep their values.
- R3: req_size selects the narrow width n: 0 gives 8 bits (8 lanes), 1 gives 16 bits (4 lanes), and 2 or 3 give 32 bits (2 lanes). Lane i reads source bits [2n*i +: 2n] and its result occupies bits [n*i +: n] of the packed 64-bit half.
- R4: The shift amount req_shamt is between 1 and n. The shift is arithmetic when req_src_signed=1 in a saturating mode, and logical otherwise.
- R5: When req_round=1, the value 2^(shamt-1) is added to the extended source before the shift. The add keeps its carry even for 64-bit sources; for example, an unsigned 64-bit all-ones source with shift 32 rounds to 2^32.
- R6: With req_mode[1]=1 and req_src_signed=1, each result is clamped to [-2^(n-1), 2^(n-1)-1].
- R7: With req_mode=01, each result is clamped to [0, 2^n-1], so negative signed sources give 0. With req_mode[1]=1 and req_src_signed=0, the unit also clamps to the unsigned range.
- R8: With req_mode=00 (truncate), the shift is logical whatever req_src_signed says, the low n bits of each lane are kept, and rsp_sat is 0.
- R9: rsp_sat is the OR of the clamp events of every lane that contributes to rsp_data.
- R10: With req_upper=1 and req_scalar=0, the packed results occupy rsp_data[127:64] and rsp_data[63:0] equals req_dst[63:0].
- R11: In the low form (req_upper=0), rsp_data[127:64] is zero.
- R12: With req_scalar=1, only lane 0 is produced at bits [n-1:0], every other bit is zero, req_upper is ignored, and rsp_sat reflects lane 0 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; every request is accepted |
| req_src | input | 128 | Wide-element source vector |
| req_dst | input | 128 | Prior destination value; lower half is kept in the upper-half form |
| req_size | input | 2 | Narrow width select: 0=8, 1=16, 2/3=32 bits |
| req_shamt | input | 6 | Right-shift amount, 1..n |
| req_round | input | 1 | Add rounding constant before the shift |
| req_src_signed | input | 1 | Source elements are signed |
| req_mode | input | 2 | 00 truncate, 01 unsigned clamp, 1x signed clamp |
| req_upper | input | 1 | Write results to the upper 64 bits |
| req_scalar | input | 1 | Produce element 0 only |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_data | output | 128 | Narrowed result vector |
| rsp_sat | output | 1 | Some contributing lane was clamped |

## Verification
Directed vectors are built so that each one gives a different answer for exactly one feature. An all-ones 64-bit source with shift 32 and rounding gives a different result if the rounding carry is lost. A negative 32-bit source gives different results for the arithmetic and logical shifts. Values of 0x7FFF and 0x8000 fall just past each signed bound. A negative signed source sent to the unsigned clamp must give zero. A mixed sweep of sizes, shifts and modes, with random and extreme lane values, is compared against a reference model in the bench. Further vectors separate the upper-half and low forms: whether req_dst survives, whether the top half is cleared, and whether scalar mode ignores the other lanes, including their clamp events.

// File: rtl/shrn_pkg.sv
// Shared constants and types for the shift-right-narrow unit.
// Assumes a 128-bit vector whose results fill one 64-bit half.
package shrn_pkg;
    localparam int VEC_W     = 128;
    localparam int HALF_W    = VEC_W / 2;
    localparam int NUM_SIZES = 3;
    localparam int MIN_NW    = 8;
    localparam int MAX_LANES = HALF_W / MIN_NW;
    localparam int SHAMT_W   = 6;
    localparam int SEL_W     = 2;

    // Per-request narrowing treatment; both 1x codes select signed clamping.
    typedef enum logic [1:0] {
        MODE_TRUNC = 2'b00,
        MODE_USAT  = 2'b01,
        MODE_SSAT  = 2'b10,
        MODE_SSAT2 = 2'b11
    } sat_mode_e;

    // Map the size field to a bank index; code 3 is treated like code 2.
    function automatic logic [SEL_W-1:0] size_to_sel(input logic [1:0] size);
        return (size == 2'd3) ? SEL_W'(2) : SEL_W'(size);
    endfunction
endpackage

// File: rtl/shrn_lane.sv
// One lane: extend a 2*NW-bit element, optionally round, shift right, then
// clamp or truncate to NW bits. Assumes 1 <= shamt_i <= NW. The internal width
// of 2*NW+2 bits keeps the rounding carry and the sign.
module shrn_lane #(
    parameter int NW = 8
) (
    input  logic [2*NW-1:0]              wide_i,
    input  logic [shrn_pkg::SHAMT_W-1:0] shamt_i,
    input  logic                         round_i,
    input  logic                         src_signed_i,
    input  shrn_pkg::sat_mode_e          mode_i,
    output logic [NW-1:0]                narrow_o,
    output logic                         sat_o
);
    import shrn_pkg::*;

    localparam int WW = 2 * NW;
    localparam int EW = WW + 2;
    localparam logic [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};
    localparam logic signed [EW-1:0] S_MAX = $signed((ONE << (NW - 1)) - ONE);
    localparam logic signed [EW-1:0] S_MIN = -$signed(ONE << (NW - 1));
    localparam logic signed [EW-1:0] U_MAX = $signed((ONE << NW) - ONE);

    logic                 sign_path;
    logic                 dst_signed;
    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] rconst;
    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] shifted;
    logic signed [EW-1:0] hi_lim;
    logic signed [EW-1:0] lo_lim;

    // Choose the extension and the clamp range from the mode and the source sign.
    always_comb begin
        sign_path  = src_signed_i && (mode_i != MODE_TRUNC);
        dst_signed = sign_path && mode_i[1];
        ext        = sign_path ? $signed({{2{wide_i[WW-1]}}, wide_i})
                               : $signed({2'b00, wide_i});
        hi_lim     = dst_signed ? S_MAX : U_MAX;
        lo_lim     = dst_signed ? S_MIN : '0;
    end

    // Add the rounding constant at full width, then shift arithmetically.
    always_comb begin
        rconst  = (round_i && shamt_i != '0) ? $signed(ONE << (shamt_i - 6'd1)) : '0;
        sum     = ext + rconst;
        shifted = sum >>> shamt_i;
    end

    // Clamp to the destination range, or keep the low bits in truncate mode.
    always_comb begin
        sat_o    = 1'b0;
        narrow_o = shifted[NW-1:0];
        if (mode_i != MODE_TRUNC) begin
            if (shifted > hi_lim) begin
                narrow_o = hi_lim[NW-1:0];
                sat_o    = 1'b1;
            end else if (shifted < lo_lim) begin
                narrow_o = lo_lim[NW-1:0];
                sat_o    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/shrn_bank.sv
// All lanes for one narrow width NW across the 128-bit source. It produces a
// packed 64-bit half and per-lane clamp flags padded to MAX_LANES bits.
module shrn_bank #(
    parameter int NW = 8
) (
    input  logic [shrn_pkg::VEC_W-1:0]     src_i,
    input  logic [shrn_pkg::SHAMT_W-1:0]   shamt_i,
    input  logic                           round_i,
    input  logic                           src_signed_i,
    input  shrn_pkg::sat_mode_e            mode_i,
    output logic [shrn_pkg::HALF_W-1:0]    packed_o,
    output logic [shrn_pkg::MAX_LANES-1:0] sat_o
);
    import shrn_pkg::*;

    localparam int LANES = HALF_W / NW;

    // One lane per wide element.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        shrn_lane #(.NW(NW)) u_lane (
            .wide_i      (src_i[2*NW*i +: 2*NW]),
            .shamt_i     (shamt_i),
            .round_i     (round_i),
            .src_signed_i(src_signed_i),
            .mode_i      (mode_i),
            .narrow_o    (packed_o[NW*i +: NW]),
            .sat_o       (sat_o[i])
        );
    end

    // Flag bits beyond this width's lane count are held low.
    for (genvar j = LANES; j < MAX_LANES; j++) begin : g_pad
        assign sat_o[j] = 1'b0;
    end
endmodule

// File: rtl/shrn_place.sv
// Places the packed narrow half into the 128-bit result. The low form clears
// the upper half; the upper-half form keeps dst[63:0]; scalar keeps lane 0 only.
module shrn_place (
    input  logic [shrn_pkg::HALF_W-1:0]    packed_i,
    input  logic [shrn_pkg::MAX_LANES-1:0] lane_sat_i,
    input  logic [shrn_pkg::SEL_W-1:0]     sel_i,
    input  logic                           upper_i,
    input  logic                           scalar_i,
    input  logic [shrn_pkg::VEC_W-1:0]     dst_i,
    output logic [shrn_pkg::VEC_W-1:0]     res_o,
    output logic                           sat_o
);
    import shrn_pkg::*;

    logic [HALF_W-1:0] elem0_mask;
    logic [HALF_W-1:0] half;

    // Mask of lane 0 for the selected narrow width.
    always_comb begin
        case (sel_i)
            2'd0:    elem0_mask = HALF_W'({MIN_NW{1'b1}});
            2'd1:    elem0_mask = HALF_W'({(2*MIN_NW){1'b1}});
            default: elem0_mask = HALF_W'({(4*MIN_NW){1'b1}});
        endcase
    end

    // Choose the contributing lanes and their position in the vector.
    always_comb begin
        half  = scalar_i ? (packed_i & elem0_mask) : packed_i;
        sat_o = scalar_i ? lane_sat_i[0] : |lane_sat_i;
        if (upper_i && !scalar_i) begin
            res_o = {half, dst_i[HALF_W-1:0]};
        end else begin
            res_o = {{HALF_W{1'b0}}, half};
        end
    end
endmodule

// File: rtl/shrn_unit.sv
// Top of the shift-right-narrow unit. It accepts a request on every valid cycle
// and registers the placed result and the clamp flag one cycle later.
// Assumes the request fields are legal (1 <= shamt <= narrow width).
module shrn_unit (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [127:0] req_src,
    input  logic [127:0] req_dst,
    input  logic [1:0]   req_size,
    input  logic [5:0]   req_shamt,
    input  logic         req_round,
    input  logic         req_src_signed,
    input  logic [1:0]   req_mode,
    input  logic         req_upper,
    input  logic         req_scalar,
    output logic         rsp_valid,
    output logic [127:0] rsp_data,
    output logic         rsp_sat
);
    import shrn_pkg::*;

    sat_mode_e                     mode;
    logic [SEL_W-1:0]              sel;
    logic [NUM_SIZES-1:0][HALF_W-1:0]    bank_half;
    logic [NUM_SIZES-1:0][MAX_LANES-1:0] bank_sat;
    logic [VEC_W-1:0]              placed;
    logic                          placed_sat;

    assign req_ready = 1'b1;

    // Decode the mode and width-select fields.
    always_comb begin
        mode = sat_mode_e'(req_mode);
        sel  = size_to_sel(req_size);
    end

    // One lane bank per supported narrow width.
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_bank
        shrn_bank #(.NW(MIN_NW << k)) u_bank (
            .src_i       (req_src),
            .shamt_i     (req_shamt),
            .round_i     (req_round),
            .src_signed_i(req_src_signed),
            .mode_i      (mode),
            .packed_o    (bank_half[k]),
            .sat_o       (bank_sat[k])
        );
    end

    shrn_place u_place (
        .packed_i  (bank_half[sel]),
        .lane_sat_i(bank_sat[sel]),
        .sel_i     (sel),
        .upper_i   (req_upper),
        .scalar_i  (req_scalar),
        .dst_i     (req_dst),
        .res_o     (placed),
        .sat_o     (placed_sat)
    );

    // Register the response; data and flag change only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_sat   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_data <= placed;
                rsp_sat  <= placed_sat;
            end
        end
    end
endmodule

// File: rtl/shrn_unit_chk.sv
// Protocol and placement properties for shrn_unit, attached by bind.
module shrn_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [127:0] req_dst,
    input logic [1:0]   req_size,
    input logic [1:0]   req_mode,
    input logic         req_upper,
    input logic         req_scalar,
    input logic         rsp_valid,
    input logic [127:0] rsp_data,
    input logic         rsp_sat
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_data) && $stable(rsp_sat)));
    p_trunc_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00) |=> !rsp_sat);
    p_upper_keeps_dst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_upper && !req_scalar) |=> (rsp_data[63:0] == $past(req_dst[63:0])));
    p_low_clears_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_upper) |=> (rsp_data[127:64] == 64'd0));
    p_scalar_byte_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_scalar && req_size == 2'd0) |=> (rsp_data[127:8] == 120'd0));
endmodule

bind shrn_unit shrn_unit_chk u_shrn_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dst   (req_dst),
    .req_size  (req_size),
    .req_mode  (req_mode),
    .req_upper (req_upper),
    .req_scalar(req_scalar),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_sat   (rsp_sat)
);

// File: tb/test_shrn_unit.sv
// Directed scenarios plus a reference-model sweep for shrn_unit.
module test_shrn_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [127:0] req_src = '0;
    logic [127:0] req_dst = '0;
    logic [1:0]   req_size = '0;
    logic [5:0]   req_shamt = 6'd1;
    logic         req_round = 1'b0;
    logic         req_src_signed = 1'b0;
    logic [1:0]   req_mode = '0;
    logic         req_upper = 1'b0;
    logic         req_scalar = 1'b0;
    logic         rsp_valid;
    logic [127:0] rsp_data;
    logic         rsp_sat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shrn_unit i_shrn_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_size(req_size),
        .req_shamt(req_shamt), .req_round(req_round), .req_src_signed(req_src_signed),
        .req_mode(req_mode), .req_upper(req_upper), .req_scalar(req_scalar),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_sat(rsp_sat)
    );

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp,
                         input logic gs, input logic es);
        checks++;
        if (got !== exp || gs !== es) begin
            failures++;
            $display("FAIL %s: data=%h sat=%b expected data=%h sat=%b", tag, got, gs, exp, es);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void model(input logic [127:0] src, input logic [127:0] dst,
                                  input logic [1:0] sz, input logic [5:0] sh,
                                  input logic rnd, input logic ss, input logic [1:0] md,
                                  input logic up, input logic sc,
                                  output logic [127:0] res, output logic sat);
        int n;
        int cnt;
        logic [63:0] half;
        n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        cnt = sc ? 1 : 64 / n;
        half = '0;
        sat = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            logic [63:0] w;
            logic signed [71:0] v;
            logic signed [71:0] hi;
            logic signed [71:0] lo;
            logic sgn;
            w = 64'(src >> (2 * n * i));
            if (2 * n < 64) w = w & ((64'd1 << (2 * n)) - 64'd1);
            sgn = ss && (md != 2'b00);
            v = $signed({8'd0, w});
            if (sgn && w[2*n-1]) v = v - (72'sd1 <<< (2 * n));
            if (rnd) v = v + (72'sd1 <<< (sh - 1));
            v = v >>> sh;
            if (md != 2'b00) begin
                if (sgn && md[1]) begin
                    hi = (72'sd1 <<< (n - 1)) - 72'sd1;
                    lo = -(72'sd1 <<< (n - 1));
                end else begin
                    hi = (72'sd1 <<< n) - 72'sd1;
                    lo = 72'sd0;
                end
                if (v > hi) begin v = hi; sat = 1'b1; end
                else if (v < lo) begin v = lo; sat = 1'b1; end
            end
            half = half | ((64'(v) & ((64'd1 << n) - 64'd1)) << (n * i));
        end
        res = (up && !sc) ? {half, dst[63:0]} : {64'd0, half};
    endfunction

    // Issue one request and return the registered response.
    task automatic run_op(input logic [127:0] src, input logic [127:0] dst, input logic [1:0] sz,
                          input logic [5:0] sh, input logic rnd, input logic ss,
                          input logic [1:0] md, input logic up, input logic sc,
                          output logic [127:0] data, output logic sat);
        @(negedge clk);
        req_src = src; req_dst = dst; req_size = sz; req_shamt = sh; req_round = rnd;
        req_src_signed = ss; req_mode = md; req_upper = up; req_scalar = sc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1) begin
            failures++;
            $display("FAIL R2: rsp_valid=%b expected 1", rsp_valid);
        end
        data = rsp_data;
        sat = rsp_sat;
    endtask

    task automatic t_reset;
        check("R1 reset state", rsp_data, '0, rsp_sat, 1'b0);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid);
        end
    endtask

    task automatic t_round_carry;
        logic [127:0] d; logic s;
        run_op({128{1'b1}}, '0, 2'd2, 6'd32, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, d, s);
        check("R5 64-bit rounding carry", d, {64'd0, {64{1'b1}}}, s, 1'b1);
        run_op({112'd0, 16'h0006}, '0, 2'd0, 6'd2, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, d, s);
        check("R5 rounding up", d, 128'd2, s, 1'b0);
        run_op({112'd0, 16'h0006}, '0, 2'd0, 6'd2, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, d, s);
        check("R5 no rounding", d, 128'd1, s, 1'b0);
    endtask

    task automatic t_signed_sat;
        logic [127:0] d; logic s;
        run_op({96'd0, 16'h8000, 16'h7FFF}, '0, 2'd0, 6'd1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, d, s);
        check("R6 signed clamp both bounds", d, 128'h807F, s, 1'b1);
        run_op({96'd0, 16'hFF00, 16'h00FE}, '0, 2'd0, 6'd1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, d, s);
        check("R6 in range no clamp", d, 128'h807F, s, 1'b0);
    endtask

    task automatic t_shift_kind;
        logic [127:0] d; logic s;
        run_op({96'd0, 32'hFFFF_FFF0}, '0, 2'd1, 6'd4, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, d, s);
        check("R4 arithmetic shift", d, 128'hFFFF, s, 1'b0);
        run_op({96'd0, 32'hFFFF_FFF0}, '0, 2'd1, 6'd4, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, d, s);
        check("R4 logical shift clamps", d, 128'hFFFF, s, 1'b1);
        run_op({96'd0, 32'hFFFF_FFF0}, '0, 2'd1, 6'd16, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, d, s);
        check("R7 unsigned source with signed code", d, 128'hFFFF, s, 1'b0);
    endtask

    task automatic t_unsigned_dst;
        logic [127:0] d; logic s;
        run_op({112'd0, 16'hFFFE}, '0, 2'd0, 6'd1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, d, s);
        check("R7 negative to zero", d, 128'd0, s, 1'b1);
    endtask

    task automatic t_truncate;
        logic [127:0] d; logic s;
        run_op({64'd0, 64'hF234_5678_9ABC_DEF0}, '0, 2'd2, 6'd4, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, d, s);
        check("R8 truncate ignores sign", d, 128'h89AB_CDEF, s, 1'b0);
    endtask

    task automatic t_placement;
        logic [127:0] d; logic s;
        logic [127:0] dst;
        dst = 128'hAAAA_BBBB_CCCC_DDDD_1122_3344_5566_7788;
        run_op({16'h0800, 16'h0700, 16'h0600, 16'h0500, 16'h0400, 16'h0300, 16'h0200, 16'h0100},
               dst, 2'd0, 6'd8, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, d, s);
        check("R10 upper form keeps dst low", d, {64'h0807_0605_0403_0201, dst[63:0]}, s, 1'b0);
        check("R3 lane order", {64'd0, d[127:64]}, 128'h0807_0605_0403_0201, 1'b0, 1'b0);
        run_op({16'h0800, 16'h0700, 16'h0600, 16'h0500, 16'h0400, 16'h0300, 16'h0200, 16'h0100},
               dst, 2'd0, 6'd8, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, d, s);
        check("R11 low form clears top", d, 128'h0807_0605_0403_0201, s, 1'b0);
    endtask

    task automatic t_scalar;
        logic [127:0] d; logic s;
        run_op({96'd0, 16'h7FFF, 16'h0040}, {128{1'b1}}, 2'd0, 6'd1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, d, s);
        check("R12 scalar lane 0 only", d, 128'h20, s, 1'b0);
        check("R9 scalar ignores other clamps", 128'd0, 128'd0, s, 1'b0);
        run_op({96'd0, 16'h7FFF, 16'h0040}, '0, 2'd0, 6'd1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, d, s);
        check("R9 any lane clamps", d, 128'h7F20, s, 1'b1);
    endtask

    task automatic t_hold;
        logic [127:0] d; logic s;
        run_op({96'd0, 32'h0001_0000}, '0, 2'd1, 6'd16, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, d, s);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2: idle rsp_valid=%b expected 0", rsp_valid);
        end
        check("R2 idle hold", rsp_data, 128'd1, rsp_sat, 1'b0);
    endtask

    task automatic t_sweep;
        for (int it = 0; it < 300; it++) begin
            logic [127:0] src; logic [127:0] dst; logic [127:0] d; logic [127:0] e;
            logic s; logic es; logic [1:0] sz; logic [5:0] sh; logic [1:0] md;
            logic rnd; logic ss; logic up; logic sc;
            int n;
            src = {$urandom, $urandom, $urandom, $urandom};
            if (it % 4 == 1) src = {4{32'h7FFF_8000}};
            if (it % 4 == 2) src = {4{32'h8000_7FFF}} ^ {4{$urandom}} & {4{32'h0000_FFFF}};
            dst = {$urandom, $urandom, $urandom, $urandom};
            sz = 2'($urandom % 4);
            n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
            sh = 6'(1 + ($urandom % n));
            md = 2'($urandom % 4);
            ss = 1'($urandom);
            if (md == 2'b00) ss = 1'($urandom);
            rnd = 1'($urandom); up = 1'($urandom); sc = ($urandom % 5) == 0;
            run_op(src, dst, sz, sh, rnd, ss, md, up, sc, d, s);
            model(src, dst, sz, sh, rnd, ss, md, up, sc, e, es);
            check("R3 sweep vs model", d, e, s, es);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_round_carry();
        t_signed_sat();
        t_shift_kind();
        t_unsigned_dst();
        t_truncate();
        t_placement();
        t_scalar();
        t_hold();
        t_sweep();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule